// File: doc/BRIEF.md
# Variable-Latency Media Front End

This block sits between a generic memory controller and a storage medium whose access time is not fixed and can have a long tail. It supports only reads and writes and makes no assumption about the medium type. A read is handled in two phases. First the read command is sent to the medium and the request is parked in a tag-indexed slot. Later the medium reports that the data for that tag is ready, and only then does the block ask the controller to run the data burst for it.

Writes are taken off the controller into a small buffer next to the medium. The buffer forwards entries to the medium oldest first. It holds each entry until the medium reports that this write has completed, and it refuses new writes while every entry is in use.

Every data path is valid/ready. A transfer happens on a rising edge where both valid and ready are high. A source that raises valid must keep valid and its payload unchanged until ready is seen. The controller may hold `burst_ready` low for any length of time. `rd_cmd_ready` and `wr_ready` fall only when the block has no free slot or buffer entry. The medium read-issue output and the completion inputs are single-cycle pulses with no handshake.

Top module: `nvm_media_frontend`

## Requirements
- R1: After reset `rd_cmd_ready`=1, `wr_ready`=1, `burst_valid`=0, `med_wr_valid`=0, `wb_count`=0 and `wb_full`=0.
- R2: In the cycle a read command transfers, `med_rd_valid`=1 and `med_rd_addr` equals the command address. `med_rd_tag` is the lowest-numbered free slot (0 to 7).
- R3: At most 8 reads are outstanding. While all 8 slots are busy, `rd_cmd_ready`=0 and `med_rd_valid` stays 0 even if `rd_cmd_valid`=1.
- R4: No burst request exists for a tag before the medium reports it ready. A ready pulse on `med_rd_done` with `med_rd_done_tag` makes `burst_valid`=1 from the next cycle.
- R5: Burst requests come out in the order in which ready indications arrived, not in issue order. Each carries the tag and the address given when that read was issued.
- R6: While `burst_valid`=1 and `burst_ready`=0, `burst_valid`, `burst_tag` and `burst_addr` stay unchanged.
- R7: A read slot is freed when its burst request transfers, and it can be allocated again from the next cycle.
- R8: A ready indication for a tag that is not waiting for data (free, or already reported ready) is ignored and produces no extra burst.
- R9: A write transfers when `wb_count` < 4 (default depth). `wb_count` rises by one in the cycle after the transfer.
- R10: With 4 entries held, `wb_full`=1 and `wr_ready`=0. An offered write is then not taken and `wb_count` stays 4.
- R11: Buffered writes are presented on `med_wr_valid`/`med_wr_addr`/`med_wr_data` in the order accepted, with the data unchanged.
- R12: Handing a write to the medium does not free its entry. Only a `med_wr_done` pulse frees the oldest handed-over entry. A write transfer and a completion in the same cycle leave `wb_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd_valid | input | 1 | Controller offers a read |
| rd_cmd_ready | output | 1 | A read slot is free |
| rd_cmd_addr | input | ADDR_W | Read address |
| med_rd_valid | output | 1 | Read command pulse to the medium |
| med_rd_tag | output | TAG_W | Slot tag of the issued read |
| med_rd_addr | output | ADDR_W | Address of the issued read |
| med_rd_done | input | 1 | Medium reports read data ready |
| med_rd_done_tag | input | TAG_W | Tag whose data is ready |
| burst_valid | output | 1 | Request for the controller to run a data burst |
| burst_ready | input | 1 | Controller takes the burst request |
| burst_tag | output | TAG_W | Tag of the burst |
| burst_addr | output | ADDR_W | Address of the burst |
| wr_valid | input | 1 | Controller offers a write |
| wr_ready | output | 1 | Write buffer has room |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| med_wr_valid | output | 1 | Oldest buffered write not yet handed to the medium |
| med_wr_ready | input | 1 | Medium takes the write |
| med_wr_addr | output | ADDR_W | Address of the presented write |
| med_wr_data | output | DATA_W | Data of the presented write |
| med_wr_done | input | 1 | Medium completed the oldest handed-over write |
| wb_count | output | $clog2(WB_DEPTH+1) | Occupied buffer entries |
| wb_full | output | 1 | All buffer entries occupied |

## Verification
The bench fills all eight read slots and then returns ready indications in several permuted orders. A design that replays issue order, or that looks up the wrong slot's address, sends bursts to the wrong place. A duplicated ready for an already-ready tag would produce a ninth burst, and a slot freed late or allocated from the wrong end would show up as the wrong tag on the next read. On the write side, the bench fills the buffer while the medium is stalled, then hands over entries without completing them. A design that frees on hand-over instead of on completion drops `wb_count` too early. Simultaneous accept and completion catches counters that lose one of the two updates.

// File: rtl/nvmfe_pkg.sv
package nvmfe_pkg;
  localparam int unsigned DEF_ADDR_W   = 16;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_RD_SLOTS = 8;
  localparam int unsigned DEF_WB_DEPTH = 4;

  // circular pointer step for a ring of 'depth' positions
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/nvmfe_rd_tracker.sv
module nvmfe_rd_tracker #(
  parameter int unsigned SLOTS  = nvmfe_pkg::DEF_RD_SLOTS,
  parameter int unsigned ADDR_W = nvmfe_pkg::DEF_ADDR_W,
  localparam int unsigned TW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              any_free,
  output logic [TW-1:0]     free_tag,
  input  logic              done_valid,
  input  logic [TW-1:0]     done_tag,
  output logic              done_hit,
  input  logic              release_en,
  input  logic [TW-1:0]     release_tag,
  input  logic [TW-1:0]     look_tag,
  output logic [ADDR_W-1:0] look_addr
);
  logic [SLOTS-1:0] busy;
  logic [SLOTS-1:0] waiting;
  logic [ADDR_W-1:0] slot_addr [SLOTS];

  always_comb begin
    free_tag = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!busy[i]) free_tag = TW'(i);
  end

  assign any_free  = ~&busy;
  assign done_hit  = done_valid && waiting[done_tag];
  assign look_addr = slot_addr[look_tag];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[g]    <= 1'b0;
        waiting[g] <= 1'b0;
      end else if (alloc && free_tag == TW'(g)) begin
        busy[g]    <= 1'b1;
        waiting[g] <= 1'b1;
      end else begin
        if (done_hit && done_tag == TW'(g)) waiting[g] <= 1'b0;
        if (release_en && release_tag == TW'(g)) busy[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc && free_tag == TW'(g)) slot_addr[g] <= alloc_addr;
    end
  end
endmodule

// File: rtl/nvmfe_tag_fifo.sv
module nvmfe_tag_fifo #(
  parameter int unsigned DEPTH = nvmfe_pkg::DEF_RD_SLOTS,
  parameter int unsigned W     = 3,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_val,
  input  logic         pop,
  output logic         not_empty,
  output logic [W-1:0] head
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;

  assign not_empty = (fill != '0);
  assign head      = store[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= PW'(nvmfe_pkg::ring_next(int'(wp), DEPTH));
      if (pop)  rp <= PW'(nvmfe_pkg::ring_next(int'(rp), DEPTH));
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= push_val;
  end
endmodule

// File: rtl/nvmfe_wr_buffer.sv
module nvmfe_wr_buffer #(
  parameter int unsigned DEPTH  = nvmfe_pkg::DEF_WB_DEPTH,
  parameter int unsigned ADDR_W = nvmfe_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = nvmfe_pkg::DEF_DATA_W,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              done,
  output logic [CW-1:0]     count,
  output logic              full
);
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [PW-1:0] wp, ip;
  logic [CW-1:0] held, handed;
  logic in_fire, out_fire, done_ok;

  assign in_ready  = (held < CW'(DEPTH));
  assign full      = (held == CW'(DEPTH));
  assign count     = held;
  assign out_valid = (held != handed);
  assign out_addr  = ent_addr[ip];
  assign out_data  = ent_data[ip];
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign done_ok   = done && (handed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      ip     <= '0;
      held   <= '0;
      handed <= '0;
    end else begin
      if (in_fire)  wp <= PW'(nvmfe_pkg::ring_next(int'(wp), DEPTH));
      if (out_fire) ip <= PW'(nvmfe_pkg::ring_next(int'(ip), DEPTH));
      case ({in_fire, done_ok})
        2'b10:   held <= held + 1'b1;
        2'b01:   held <= held - 1'b1;
        default: ;
      endcase
      case ({out_fire, done_ok})
        2'b10:   handed <= handed + 1'b1;
        2'b01:   handed <= handed - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      ent_addr[wp] <= in_addr;
      ent_data[wp] <= in_data;
    end
  end
endmodule

// File: rtl/nvm_media_frontend.sv
module nvm_media_frontend #(
  parameter int unsigned ADDR_W   = nvmfe_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = nvmfe_pkg::DEF_DATA_W,
  parameter int unsigned RD_SLOTS = nvmfe_pkg::DEF_RD_SLOTS,
  parameter int unsigned WB_DEPTH = nvmfe_pkg::DEF_WB_DEPTH,
  localparam int unsigned TAG_W   = $clog2(RD_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_cmd_valid,
  output logic                          rd_cmd_ready,
  input  logic [ADDR_W-1:0]             rd_cmd_addr,
  output logic                          med_rd_valid,
  output logic [TAG_W-1:0]              med_rd_tag,
  output logic [ADDR_W-1:0]             med_rd_addr,
  input  logic                          med_rd_done,
  input  logic [TAG_W-1:0]              med_rd_done_tag,
  output logic                          burst_valid,
  input  logic                          burst_ready,
  output logic [TAG_W-1:0]              burst_tag,
  output logic [ADDR_W-1:0]             burst_addr,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          med_wr_valid,
  input  logic                          med_wr_ready,
  output logic [ADDR_W-1:0]             med_wr_addr,
  output logic [DATA_W-1:0]             med_wr_data,
  input  logic                          med_wr_done,
  output logic [$clog2(WB_DEPTH+1)-1:0] wb_count,
  output logic                          wb_full
);
  logic rd_fire, burst_fire, ready_push;

  assign rd_fire      = rd_cmd_valid && rd_cmd_ready;
  assign burst_fire   = burst_valid && burst_ready;
  assign med_rd_valid = rd_fire;
  assign med_rd_addr  = rd_cmd_addr;

  nvmfe_rd_tracker #(.SLOTS(RD_SLOTS), .ADDR_W(ADDR_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc       (rd_fire),
    .alloc_addr  (rd_cmd_addr),
    .any_free    (rd_cmd_ready),
    .free_tag    (med_rd_tag),
    .done_valid  (med_rd_done),
    .done_tag    (med_rd_done_tag),
    .done_hit    (ready_push),
    .release_en  (burst_fire),
    .release_tag (burst_tag),
    .look_tag    (burst_tag),
    .look_addr   (burst_addr)
  );

  nvmfe_tag_fifo #(.DEPTH(RD_SLOTS), .W(TAG_W)) u_ready_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ready_push),
    .push_val  (med_rd_done_tag),
    .pop       (burst_fire),
    .not_empty (burst_valid),
    .head      (burst_tag)
  );

  nvmfe_wr_buffer #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_addr   (wr_addr),
    .in_data   (wr_data),
    .out_valid (med_wr_valid),
    .out_ready (med_wr_ready),
    .out_addr  (med_wr_addr),
    .out_data  (med_wr_data),
    .done      (med_wr_done),
    .count     (wb_count),
    .full      (wb_full)
  );
endmodule

// File: rtl/nvm_media_frontend_chk.sv
module nvm_media_frontend_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TAG_W    = 3,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned CW      = $clog2(WB_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_cmd_ready,
  input logic              med_rd_valid,
  input logic              burst_valid,
  input logic              burst_ready,
  input logic [TAG_W-1:0]  burst_tag,
  input logic [ADDR_W-1:0] burst_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              med_wr_valid,
  input logic              med_wr_ready,
  input logic [ADDR_W-1:0] med_wr_addr,
  input logic              med_wr_done,
  input logic [CW-1:0]     wb_count,
  input logic              wb_full
);
  assert_no_issue_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd_ready |-> !med_rd_valid);

  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_tag) && $stable(burst_addr)));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_count <= CW'(WB_DEPTH));

  assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full |-> !wr_ready);

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (med_wr_valid && !med_wr_ready) |=> (med_wr_valid && $stable(med_wr_addr)));

  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !med_wr_done) |=> (wb_count == $past(wb_count) + 1'b1));
endmodule

bind nvm_media_frontend nvm_media_frontend_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WB_DEPTH(WB_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_cmd_ready (rd_cmd_ready),
  .med_rd_valid (med_rd_valid),
  .burst_valid  (burst_valid),
  .burst_ready  (burst_ready),
  .burst_tag    (burst_tag),
  .burst_addr   (burst_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .med_wr_valid (med_wr_valid),
  .med_wr_ready (med_wr_ready),
  .med_wr_addr  (med_wr_addr),
  .med_wr_done  (med_wr_done),
  .wb_count     (wb_count),
  .wb_full      (wb_full)
);

// File: tb/nvm_media_frontend_tb.sv
module nvm_media_frontend_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic rd_cmd_valid = 0, rd_cmd_ready;
  logic [15:0] rd_cmd_addr = '0;
  logic med_rd_valid;
  logic [2:0] med_rd_tag;
  logic [15:0] med_rd_addr;
  logic med_rd_done = 0;
  logic [2:0] med_rd_done_tag = '0;
  logic burst_valid, burst_ready = 0;
  logic [2:0] burst_tag;
  logic [15:0] burst_addr;
  logic wr_valid = 0, wr_ready;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic med_wr_valid, med_wr_ready = 0;
  logic [15:0] med_wr_addr;
  logic [31:0] med_wr_data;
  logic med_wr_done = 0;
  logic [2:0] wb_count;
  logic wb_full;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  nvm_media_frontend u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue_read(input logic [15:0] a, input int exp_tag);
    rd_cmd_valid = 1; rd_cmd_addr = a;
    #1;
    chk(med_rd_valid == 1 && med_rd_addr == a, "R2 issue", int'(med_rd_addr), int'(a));
    chk(int'(med_rd_tag) == exp_tag, "R2 tag", int'(med_rd_tag), exp_tag);
    tick();
    rd_cmd_valid = 0;
  endtask

  task automatic ready_pulse(input int t);
    med_rd_done = 1; med_rd_done_tag = 3'(t);
    tick();
    med_rd_done = 0;
  endtask

  task automatic take_burst(input int t, input logic [15:0] a);
    #1;
    chk(burst_valid == 1 && int'(burst_tag) == t, "R5 tag order", int'(burst_tag), t);
    chk(burst_addr == a, "R5 addr", int'(burst_addr), int'(a));
    burst_ready = 1;
    tick();
    burst_ready = 0;
  endtask

  task automatic read_round(input int mul, input int off, input logic [15:0] base);
    int ord [8];
    for (int i = 0; i < 8; i++) issue_read(base + 16'(i), i);
    rd_cmd_valid = 1; rd_cmd_addr = base;
    #1;
    chk(rd_cmd_ready == 0 && med_rd_valid == 0, "R3 full table", int'(med_rd_valid), 0);
    tick();
    rd_cmd_valid = 0;
    chk(burst_valid == 0, "R4 no burst before ready", int'(burst_valid), 0);
    for (int k = 0; k < 8; k++) ord[k] = (k * mul + off) % 8;
    for (int k = 0; k < 8; k++) begin
      ready_pulse(ord[k]);
      chk(burst_valid == 1, "R4 burst after ready", int'(burst_valid), 1);
    end
    ready_pulse(ord[0]);  // R8 duplicate ready
    for (int c = 0; c < 2; c++) begin
      tick();
      chk(int'(burst_tag) == ord[0] && burst_valid, "R6 hold", int'(burst_tag), ord[0]);
    end
    for (int k = 0; k < 8; k++) take_burst(ord[k], base + 16'(ord[k]));
    chk(burst_valid == 0, "R8 no extra burst", int'(burst_valid), 0);
    chk(rd_cmd_ready == 1, "R7 slots free", int'(rd_cmd_ready), 1);
  endtask

  task automatic reuse_check();
    for (int i = 0; i < 8; i++) issue_read(16'h0800 + 16'(i), i);
    ready_pulse(5);
    take_burst(5, 16'h0805);
    chk(rd_cmd_ready == 1, "R7 freed slot", int'(rd_cmd_ready), 1);
    issue_read(16'h0900, 5);
    ready_pulse(7);  // R8 tag 7 waiting: accepted
    ready_pulse(5);
    take_burst(7, 16'h0807);
    take_burst(5, 16'h0900);
    for (int i = 0; i < 7; i++) if (i != 5) begin
      ready_pulse(i);
      take_burst(i, 16'h0800 + 16'(i));
    end
    ready_pulse(3);  // R8 tag 3 free now: ignored
    chk(burst_valid == 0, "R8 free tag ignored", int'(burst_valid), 0);
  endtask

  task automatic push_write(input logic [15:0] a, input logic [31:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    tick();
    wr_valid = 0;
  endtask

  task automatic hand_write(input int idx);
    #1;
    chk(med_wr_valid == 1 && med_wr_addr == 16'h0040 + 16'(idx), "R11 order", int'(med_wr_addr), 16'h40 + idx);
    chk(med_wr_data == 32'hA000 + 32'(idx), "R11 data", int'(med_wr_data), 32'hA000 + idx);
    med_wr_ready = 1;
    tick();
    med_wr_ready = 0;
  endtask

  task automatic write_test();
    for (int i = 0; i < 4; i++) begin
      chk(wr_ready == 1, "R9 room", int'(wr_ready), 1);
      push_write(16'h0040 + 16'(i), 32'hA000 + 32'(i));
      chk(int'(wb_count) == i + 1, "R9 count", int'(wb_count), i + 1);
    end
    chk(wb_full == 1 && wr_ready == 0, "R10 full", int'(wb_full), 1);
    push_write(16'h0099, 32'hDEAD);
    chk(int'(wb_count) == 4, "R10 refused", int'(wb_count), 4);
    hand_write(0);
    hand_write(1);
    chk(int'(wb_count) == 4, "R12 handed not freed", int'(wb_count), 4);
    med_wr_done = 1; tick(); med_wr_done = 0;
    chk(int'(wb_count) == 3 && wr_ready == 1, "R12 done frees", int'(wb_count), 3);
    med_wr_done = 1; wr_valid = 1; wr_addr = 16'h0044; wr_data = 32'hA004;
    tick();
    med_wr_done = 0; wr_valid = 0;
    chk(int'(wb_count) == 3, "R12 accept+done", int'(wb_count), 3);
    for (int i = 2; i < 5; i++) hand_write(i);
    chk(med_wr_valid == 0, "R11 drained", int'(med_wr_valid), 0);
    for (int i = 0; i < 3; i++) begin
      med_wr_done = 1; tick(); med_wr_done = 0;
      chk(int'(wb_count) == 2 - i, "R12 release", int'(wb_count), 2 - i);
    end
    chk(wb_full == 0, "R10 not full", int'(wb_full), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(rd_cmd_ready == 1 && wr_ready == 1, "R1 ready", int'(rd_cmd_ready), 1);
    chk(burst_valid == 0 && med_wr_valid == 0, "R1 idle", int'(burst_valid), 0);
    chk(wb_count == 0 && wb_full == 0, "R1 count", int'(wb_count), 0);
    @(negedge clk);
    for (int m = 1; m < 8; m += 2)
      for (int o = 0; o < 8; o += 3)
        read_round(m, o, 16'h1000 * 16'(m) + 16'h0100 * 16'(o));
    reuse_check();
    write_test();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule